// File: doc/BRIEF.md
# Prescaled interval timer

The block is a free-running interval timer. A 14-stage binary prescaler advances on one of two count-enable sources: a fast system-rate enable or a slow sub-clock enable. A clock-select control bit picks the source. A 3-bit interval code chooses one prescaler stage as the interval tick. Each rising edge of that stage produces a one-cycle interrupt request, unless the mask bit blocks it.

The block also drives two registered outputs. The timer output carries either the selected stage or, in bypass mode, the selected enable itself. A separate slow output follows the top prescaler stage and serves as the clock for an external watchdog counter.

The prescaler starts counting from zero after reset without any software action. Later, the only way to clear it is a control write with the restart bit set, and that restart is refused while the external watchdog reports that it is active. The whole block runs on one clock, and both sources are applied as clock enables.

Top module: `interval_timer_top`

## Requirements
- R1: On reset, all outputs are 0, the prescaler is 0, and the control state is: interval code 0, system source, mask set, bypass off. Once reset is released, the prescaler counts without any control write.
- R2: Control bit 4 selects the count source. 0 means `sys_en` and 1 means `sub_en`. The prescaler advances by one only in cycles where the selected enable is 1.
- R3: The interval code in control bits 2:0 selects the tick stage. Codes 0 to 7 map to prescaler bits 0, 1, 2, 3, 4, 5, 7 and 10, where stage Qn is bit n-1.
- R4: While the mask (control bit 5) is 0, `irq` is high for exactly one cycle. That cycle is the second cycle after the edge at which the selected prescaler bit went from 0 to 1.
- R5: While the mask bit is 1, `irq` stays 0.
- R6: A control write with bit 3 set clears the prescaler at that edge, provided `wdog_active` is 0. If bit 3 is 0, or if `wdog_active` is 1, the count continues.
- R7: `tmr_out` is registered and depends on the bypass bit (control bit 6). When bypass is 0 it shows the selected prescaler bit. When bypass is 1 it shows the selected enable. Either way it lags its source by one cycle.
- R8: `wdog_clk` shows prescaler bit 13, registered one cycle, whatever the interval code is.
- R9: A write stores control bits 6:4 and 2:0 at the edge where `ctl_wr` is high. Bit 3 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | System-rate count enable |
| sub_en | input | 1 | Sub-clock count enable |
| wdog_active | input | 1 | External watchdog is active, so restart is refused |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data |
| irq | output | 1 | Interval interrupt request pulse |
| tmr_out | output | 1 | Timer output (selected stage or bypassed enable) |
| wdog_clk | output | 1 | Slow clock for the watchdog counter |

## Verification
A wrong prescaler value shows up on `tmr_out` within one or two cycles when the interval code selects a low stage. A stuck high stage only shows up after up to 8192 enabled cycles, on `wdog_clk`. A control field stored in the wrong place appears as a wrong source or a wrong tick period at the next tick. A broken mask or edge detector produces an extra, missing or stretched `irq` pulse within one tick period. The bench compares every cycle against a behavioural model, so any such divergence is caught at the first cycle where it reaches a port.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CTL_W = 8;
  localparam int N_CODES = 8;
  localparam int CODE_W = $clog2(N_CODES);

  localparam int B_RESTART = 3;
  localparam int B_CSEL    = 4;
  localparam int B_MASK    = 5;
  localparam int B_BYP     = 6;

  typedef struct packed {
    logic              byp;
    logic              mask;
    logic              csel;
    logic [CODE_W-1:0] code;
  } ctl_t;

  localparam ctl_t CTL_RST = '{byp: 1'b0, mask: 1'b1, csel: 1'b0, code: '0};

  function automatic int tap_bit(input int c);
    case (c)
      6:       tap_bit = 7;
      7:       tap_bit = 10;
      default: tap_bit = c;
    endcase
  endfunction
endpackage

// File: rtl/itmr_ctl.sv
module itmr_ctl
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wdog_active,
  output ctl_t             ctl,
  output logic             restart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= CTL_RST;
    end else if (wr) begin
      ctl.code <= wdata[CODE_W-1:0];
      ctl.csel <= wdata[B_CSEL];
      ctl.mask <= wdata[B_MASK];
      ctl.byp  <= wdata[B_BYP];
    end
  end

  assign restart = wr && wdata[B_RESTART] && !wdog_active;
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PS_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            restart,
  output logic [PS_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (en)        cnt <= cnt + 1'b1;
  end

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!restart && !en) |=> $stable(cnt)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!restart && en) |=> (cnt == PS_W'($past(cnt) + 1'b1))); // R2
endmodule

// File: rtl/itmr_tap_out.sv
module itmr_tap_out
  import itmr_pkg::*;
#(
  parameter int PS_W   = 14,
  parameter int WD_TAP = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] cnt,
  input  ctl_t            ctl,
  input  logic            en_sel,
  output logic            irq,
  output logic            tmr_out,
  output logic            wdog_clk
);
  logic [N_CODES-1:0] taps;
  logic               tap, tap_d;

  for (genvar g = 0; g < N_CODES; g++) begin : g_tap
    assign taps[g] = cnt[tap_bit(g)];
  end

  assign tap = taps[ctl.code];

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_d    <= 1'b0;
      irq      <= 1'b0;
      tmr_out  <= 1'b0;
      wdog_clk <= 1'b0;
    end else begin
      tap_d    <= tap;
      irq      <= tap && !tap_d && !ctl.mask;
      tmr_out  <= ctl.byp ? en_sel : tap;
      wdog_clk <= cnt[WD_TAP];
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(ctl.mask)); // R5
endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
  import itmr_pkg::*;
#(
  parameter int PS_W   = 14,
  parameter int WD_TAP = PS_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_en,
  input  logic             sub_en,
  input  logic             wdog_active,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             irq,
  output logic             tmr_out,
  output logic             wdog_clk
);
  ctl_t            ctl;
  logic            restart;
  logic            en_sel;
  logic [PS_W-1:0] cnt;

  itmr_ctl i_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .wdog_active(wdog_active), .ctl(ctl), .restart(restart)
  );

  assign en_sel = ctl.csel ? sub_en : sys_en;

  itmr_prescaler #(.PS_W(PS_W)) i_ps (
    .clk(clk), .rst(rst), .en(en_sel), .restart(restart), .cnt(cnt)
  );

  itmr_tap_out #(.PS_W(PS_W), .WD_TAP(WD_TAP)) i_out (
    .clk(clk), .rst(rst), .cnt(cnt), .ctl(ctl), .en_sel(en_sel),
    .irq(irq), .tmr_out(tmr_out), .wdog_clk(wdog_clk)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq && !tmr_out && !wdog_clk)); // R1
endmodule

// File: tb/test_interval_timer_top.sv
module test_interval_timer_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;

  logic clk = 0, rst = 1;
  logic sys_en = 0, sub_en = 0, wdog_active = 0, ctl_wr = 0;
  logic [7:0] ctl_wdata = 0;
  logic irq, tmr_out, wdog_clk;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  interval_timer_top i_interval_timer_top (
    .clk(clk), .rst(rst), .sys_en(sys_en), .sub_en(sub_en),
    .wdog_active(wdog_active), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .irq(irq), .tmr_out(tmr_out), .wdog_clk(wdog_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model built from the requirements
  logic [13:0] m_cnt;
  logic [2:0]  m_code;
  logic m_csel, m_mask, m_byp, m_tapd, m_irq, m_out, m_wd;

  function automatic int code_bit(input logic [2:0] c);  // R3
    case (c)
      3'd6:    return 7;
      3'd7:    return 10;
      default: return int'(c);
    endcase
  endfunction

  function automatic logic sel_en(input logic cs, input logic s, input logic u);
    return cs ? u : s;  // R2
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_code <= 0; m_csel <= 0; m_mask <= 1; m_byp <= 0;
      m_tapd <= 0; m_irq <= 0; m_out <= 0; m_wd <= 0;
    end else begin
      if (ctl_wr) begin  // R9
        m_code <= ctl_wdata[2:0]; m_csel <= ctl_wdata[4];
        m_mask <= ctl_wdata[5];   m_byp  <= ctl_wdata[6];
      end
      if (ctl_wr && ctl_wdata[3] && !wdog_active) m_cnt <= 0;  // R6
      else if (sel_en(m_csel, sys_en, sub_en)) m_cnt <= m_cnt + 1;
      m_tapd <= m_cnt[code_bit(m_code)];
      m_irq  <= m_cnt[code_bit(m_code)] && !m_tapd && !m_mask;
      m_out  <= m_byp ? sel_en(m_csel, sys_en, sub_en) : m_cnt[code_bit(m_code)];
      m_wd   <= m_cnt[13];
    end
  end

  task automatic check(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s %s cyc %0d actual %b expected %b", t, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      check(tag, "irq", irq, m_irq);
      check(tag, "tmr_out", tmr_out, m_out);
      check((tag == "R8") ? "R8" : tag, "wdog_clk", wdog_clk, m_wd);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    // R1: reset state
    step(3);
    check("R1", "irq reset", irq, 1'b0);
    check("R1", "tmr_out reset", tmr_out, 1'b0);
    check("R1", "wdog_clk reset", wdog_clk, 1'b0);
    rst = 0; sys_en = 1;
    step(40);  // R1: counts with no write
    // R3, R4: every interval code, unmasked
    for (int c = 0; c < 8; c++) begin
      tag = (c % 2 == 0) ? "R3" : "R4";
      write(8'(c));
      step(4 << code_bit(3'(c)));
    end
    // R5: masked
    tag = "R5"; write(8'h22);
    for (int i = 0; i < 200; i++) begin @(negedge clk); check("R5", "irq masked", irq, 1'b0); end
    // R2: sub source with sparse enables
    tag = "R2"; write(8'h10);
    for (int i = 0; i < 600; i++) begin @(negedge clk); sub_en = ($urandom % 3) == 0; end
    write(8'h00);
    for (int i = 0; i < 300; i++) begin @(negedge clk); sys_en = $urandom % 2; sub_en = $urandom % 2; end
    sys_en = 1;
    // R6: restart accepted and refused
    tag = "R6"; write(8'h03); step(5);
    wdog_active = 0; write(8'h0b); step(10);
    wdog_active = 1; write(8'h0b); step(10);
    wdog_active = 0; write(8'h03); step(10);
    write(8'h0c); step(20);
    // R7: bypass
    tag = "R7"; write(8'h40);
    for (int i = 0; i < 100; i++) begin @(negedge clk); sys_en = $urandom % 2; end
    sys_en = 1; write(8'h02); step(40);
    // R8: long run for the top stage
    tag = "R8"; write(8'h07); step(20000);
    // R9: random mix of writes and enables
    tag = "R9";
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      sys_en = ($urandom % 4) != 0; sub_en = ($urandom % 2) == 0;
      wdog_active = ($urandom % 2) == 0;
      ctl_wr = ($urandom % 64) == 0; ctl_wdata = 8'($urandom);
    end
    ctl_wr = 0; step(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule